// File: doc/BRIEF.md
# Endpoint FIFO Unit Allocator

This block hands out regions of a shared endpoint packet memory. The memory is cut into equal units of `UNIT_BYTES` (512 bytes by default). A bitmap of `MAP_BITS` bits (128 by default, so up to 64 KB) keeps one bit per unit, and a set bit means the unit is in use. One instance serves the transmit direction and a second instance serves the receive direction. The packet datapath itself lies outside this block.

To allocate, the requester gives an endpoint's maximum packet size and a slot count. The block first rounds the packet size up to a power of two, which gives the segment size. It reserves one more segment than the slot count and rounds the byte total up to whole units. It then takes the lowest-placed free run of units that is long enough and lies below the configured limit. It marks that run as used and returns its byte address, measured from the configured memory base. To free, the requester gives a byte address and a byte length. The block clears that run, but only if every unit in the run is currently in use.

The block takes one request at a time through a valid/ready handshake. It reports every result after the same fixed number of cycles, using a one-cycle done pulse.

Top module: `fifo_unit_alloc`

## Requirements
- R1: After a synchronous active-low reset, every unit is free, `req_ready` is 1 and `rsp_done` is 0.
- R2: An allocation (`req_op` = 0) requests `ceil((req_slot + 1) * seg / UNIT_BYTES)` units. Here `seg` is the smallest power of two that is at least `req_mps`, and `seg` is 1 when `req_mps` is 0 or 1.
- R3: An allocation takes the lowest start unit whose run of requested units is entirely free. On success it responds with `rsp_err` = 0 and `rsp_addr` = `cfg_base` + start × `UNIT_BYTES`.
- R4: The run must end at or below the effective limit, which is the smaller of `cfg_limit` and `MAP_BITS`. When no such run exists, the response is `rsp_err` = 1 and `rsp_addr` = 0, and no unit changes.
- R5: Units granted by an allocation stay in use until they are freed. No later allocation overlaps them.
- R6: A free (`req_op` = 1) starts at unit (`req_addr` − `cfg_base`) / `UNIT_BYTES` and covers `ceil(req_len / UNIT_BYTES)` units. When it succeeds, it clears exactly those units and responds with `rsp_err` = 0 and `rsp_addr` = `req_addr`.
- R7: A free fails with `rsp_err` = 1 and `rsp_addr` = 0, and changes no unit, in any of these cases:
  - a unit in the run is already free;
  - the address is below the base or not aligned to a unit;
  - the length is 0;
  - the run passes the effective limit.
- R8: A request is accepted on a cycle with `req_valid` and `req_ready` both high. After that, `req_ready` stays 0 until the result is out. The result appears as a one-cycle `rsp_done` pulse in the third cycle after the accepting cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_base | input | ADDR_W | Byte address of unit 0 |
| cfg_limit | input | LIM_W | Number of usable units |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_op | input | 1 | 0 = allocate, 1 = free |
| req_mps | input | MPS_W | Maximum packet size in bytes (allocate) |
| req_slot | input | SLOT_W | Slot count (allocate) |
| req_addr | input | ADDR_W | Start byte address (free) |
| req_len | input | LEN_W | Length in bytes (free) |
| rsp_done | output | 1 | Result valid pulse |
| rsp_err | output | 1 | Request failed |
| rsp_addr | output | ADDR_W | Granted address, or echoed free address |

## Verification
If the unit bitmap holds a wrong value, it shows at the ports only through a later request. An allocation then returns a wrong address, or it overlaps a live region, or it fails when it should succeed. A free of a live region then reports an error. For this reason the bench keeps a model of the bitmap and follows every allocation and free with requests that depend on the exact state the earlier ones left behind. A wrong rounding of the size shows up as a shifted address within one or two later allocations. A latency fault shows up on the very next response.

// File: rtl/fau_pkg.sv
// Shared types for the endpoint FIFO unit allocator.
package fau_pkg;
    // Request kind carried on req_op.
    typedef enum logic {
        OP_ALLOC = 1'b0,
        OP_FREE  = 1'b1
    } fau_op_e;

    // Control sequence of one request.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SIZE = 2'd1,
        ST_EXEC = 2'd2
    } fau_state_e;
endpackage

// File: rtl/fau_size_calc.sv
// Unit count calculator.
// Purpose: turns an allocation (max packet size, slot count) or a free
// (byte length) into a number of memory units.
// Assumes: UNIT_SH is log2 of the unit size; NEED_W holds the largest count.
module fau_size_calc
    import fau_pkg::*;
#(
    parameter int MPS_W   = 11,
    parameter int SLOT_W  = 3,
    parameter int LEN_W   = 17,
    parameter int UNIT_SH = 9,
    parameter int NEED_W  = 9
) (
    input  fau_op_e           op,
    input  logic [MPS_W-1:0]  mps,
    input  logic [SLOT_W-1:0] slot,
    input  logic [LEN_W-1:0]  len,
    output logic [NEED_W-1:0] need
);
    localparam int SEG_W  = MPS_W + 1;
    localparam int TOT_W  = SEG_W + SLOT_W + 1;
    localparam int WIDE_W = ((TOT_W > LEN_W) ? TOT_W : LEN_W) + 1;

    logic [MPS_W-1:0]  mps_m1;
    logic [SEG_W-1:0]  seg;
    logic [TOT_W-1:0]  total;
    logic [WIDE_W-1:0] alloc_units;
    logic [WIDE_W-1:0] free_units;

    // Packet size less one, with 0 treated like 1.
    always_comb mps_m1 = (mps == '0) ? '0 : mps - 1'b1;

    // Power-of-two segment: one above the highest set bit of mps-1.
    always_comb begin
        seg = SEG_W'(1);
        for (int i = 0; i < MPS_W; i++) begin
            if (mps_m1[i]) seg = SEG_W'(1) << (i + 1);
        end
    end

    // One segment more than the slot count.
    always_comb total = (TOT_W'(slot) + TOT_W'(1)) * TOT_W'(seg);

    // Round both byte amounts up to whole units and pick by request kind.
    always_comb begin
        alloc_units = (WIDE_W'(total) + WIDE_W'((1 << UNIT_SH) - 1)) >> UNIT_SH;
        free_units  = (WIDE_W'(len) + WIDE_W'((1 << UNIT_SH) - 1)) >> UNIT_SH;
        need        = (op == OP_FREE) ? NEED_W'(free_units) : NEED_W'(alloc_units);
    end
endmodule

// File: rtl/fau_window_mask.sv
// Window mask builder.
// Purpose: sets the bits [start, start+need) of a MAP_BITS-wide vector.
// Assumes: bits past the top of the map are dropped; callers check range.
module fau_window_mask #(
    parameter int MAP_BITS = 128,
    parameter int IDX_W    = 7,
    parameter int NEED_W   = 9
) (
    input  logic [IDX_W-1:0]    start,
    input  logic [NEED_W-1:0]   need,
    output logic [MAP_BITS-1:0] mask
);
    logic [MAP_BITS-1:0] run;

    // Run of 'need' ones anchored at bit 0.
    always_comb begin
        for (int i = 0; i < MAP_BITS; i++) begin
            run[i] = (32'(i) < 32'(need));
        end
    end

    // Move the run to its start position.
    always_comb mask = run << start;
endmodule

// File: rtl/fau_run_finder.sv
// First-fit run finder.
// Purpose: in one cycle, finds the lowest start unit where 'need' free
// units lie entirely below 'limit'.
// Assumes: 'run' holds 'need' ones from bit 0; limit <= MAP_BITS.
module fau_run_finder #(
    parameter int MAP_BITS = 128,
    parameter int IDX_W    = 7,
    parameter int NEED_W   = 9,
    parameter int LIM_W    = 8
) (
    input  logic [MAP_BITS-1:0] used,
    input  logic [MAP_BITS-1:0] run,
    input  logic [NEED_W-1:0]   need,
    input  logic [LIM_W-1:0]    limit,
    output logic                found,
    output logic [IDX_W-1:0]    start
);
    logic [MAP_BITS-1:0] fit;

    // One fit test per candidate start position.
    for (genvar s = 0; s < MAP_BITS; s++) begin : g_pos
        localparam logic [31:0] POS = s;
        assign fit[s] = (need != '0)
                     && ((32'(need) + POS) <= 32'(limit))
                     && ((used & (run << s)) == '0);
    end

    // Lowest fitting position wins.
    always_comb begin
        found = 1'b0;
        start = '0;
        for (int i = MAP_BITS - 1; i >= 0; i--) begin
            if (fit[i]) begin
                found = 1'b1;
                start = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/fau_unit_map.sv
// Unit occupancy bitmap.
// Purpose: holds one in-use bit per memory unit; sets or clears a masked run.
// Assumes: set_en and clr_en are never high together.
module fau_unit_map #(
    parameter int MAP_BITS = 128
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                set_en,
    input  logic                clr_en,
    input  logic [MAP_BITS-1:0] mask,
    output logic [MAP_BITS-1:0] used
);
    // Apply a grant or a release to the bitmap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            used <= '0;
        end else if (set_en) begin
            used <= used | mask;
        end else if (clr_en) begin
            used <= used & ~mask;
        end
    end
endmodule

// File: rtl/fifo_unit_alloc.sv
// Endpoint FIFO unit allocator (top).
// Purpose: takes allocate and free requests one at a time, keeps the unit
// bitmap and returns each result exactly three cycles after acceptance.
// Assumes: cfg_base is unit aligned and held steady while a request runs.
module fifo_unit_alloc
    import fau_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int MAP_BITS   = 128,
    parameter int UNIT_BYTES = 512,
    parameter int MPS_W      = 11,
    parameter int SLOT_W     = 3,
    parameter int LEN_W      = 17,
    localparam int UNIT_SH   = $clog2(UNIT_BYTES),
    localparam int IDX_W     = $clog2(MAP_BITS),
    localparam int LIM_W     = $clog2(MAP_BITS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [LIM_W-1:0]  cfg_limit,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_op,
    input  logic [MPS_W-1:0]  req_mps,
    input  logic [SLOT_W-1:0] req_slot,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    output logic              rsp_done,
    output logic              rsp_err,
    output logic [ADDR_W-1:0] rsp_addr
);
    localparam int TOT_W  = MPS_W + SLOT_W + 2;
    localparam int WIDE_W = ((TOT_W > LEN_W) ? TOT_W : LEN_W) + 1;
    localparam int NEED_W = WIDE_W - UNIT_SH;

    fau_state_e          state_q;
    fau_op_e             op_q;
    logic [MPS_W-1:0]    mps_q;
    logic [SLOT_W-1:0]   slot_q;
    logic [LEN_W-1:0]    len_q;
    logic [ADDR_W-1:0]   addr_q;
    logic [NEED_W-1:0]   need_d;
    logic [NEED_W-1:0]   need_q;
    logic [IDX_W-1:0]    start_q;
    logic                addr_bad_q;
    logic [ADDR_W-1:0]   offset;
    logic                addr_bad_d;
    logic [LIM_W-1:0]    eff_limit;
    logic [MAP_BITS-1:0] used_map;
    logic [MAP_BITS-1:0] run_mask;
    logic [MAP_BITS-1:0] win_mask;
    logic                fit_found;
    logic [IDX_W-1:0]    fit_start;
    logic [IDX_W-1:0]    win_start;
    logic                free_ok;
    logic                in_exec;
    logic                set_en;
    logic                clr_en;

    assign req_ready = (state_q == ST_IDLE);
    assign in_exec   = (state_q == ST_EXEC);

    // Sequence control and capture of an accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            op_q    <= OP_ALLOC;
            mps_q   <= '0;
            slot_q  <= '0;
            len_q   <= '0;
            addr_q  <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        op_q    <= fau_op_e'(req_op);
                        mps_q   <= req_mps;
                        slot_q  <= req_slot;
                        len_q   <= req_len;
                        addr_q  <= req_addr;
                        state_q <= ST_SIZE;
                    end
                end
                ST_SIZE: state_q <= ST_EXEC;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    fau_size_calc #(
        .MPS_W  (MPS_W),
        .SLOT_W (SLOT_W),
        .LEN_W  (LEN_W),
        .UNIT_SH(UNIT_SH),
        .NEED_W (NEED_W)
    ) u_size (
        .op  (op_q),
        .mps (mps_q),
        .slot(slot_q),
        .len (len_q),
        .need(need_d)
    );

    // Free address decode: offset from base, alignment and range.
    always_comb begin
        offset     = addr_q - cfg_base;
        addr_bad_d = (addr_q < cfg_base)
                  || (offset[UNIT_SH-1:0] != '0)
                  || ((offset >> UNIT_SH) >= ADDR_W'(MAP_BITS));
    end

    // Register the size and decoded start for the execute cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            need_q     <= '0;
            start_q    <= '0;
            addr_bad_q <= 1'b0;
        end else if (state_q == ST_SIZE) begin
            need_q     <= need_d;
            start_q    <= offset[UNIT_SH +: IDX_W];
            addr_bad_q <= addr_bad_d;
        end
    end

    // Usable units: configured limit clipped to the bitmap size.
    always_comb begin
        eff_limit = (cfg_limit > LIM_W'(MAP_BITS)) ? LIM_W'(MAP_BITS) : cfg_limit;
    end

    fau_window_mask #(
        .MAP_BITS(MAP_BITS),
        .IDX_W   (IDX_W),
        .NEED_W  (NEED_W)
    ) u_run (
        .start('0),
        .need (need_q),
        .mask (run_mask)
    );

    fau_run_finder #(
        .MAP_BITS(MAP_BITS),
        .IDX_W   (IDX_W),
        .NEED_W  (NEED_W),
        .LIM_W   (LIM_W)
    ) u_find (
        .used (used_map),
        .run  (run_mask),
        .need (need_q),
        .limit(eff_limit),
        .found(fit_found),
        .start(fit_start)
    );

    assign win_start = (op_q == OP_ALLOC) ? fit_start : start_q;

    fau_window_mask #(
        .MAP_BITS(MAP_BITS),
        .IDX_W   (IDX_W),
        .NEED_W  (NEED_W)
    ) u_win (
        .start(win_start),
        .need (need_q),
        .mask (win_mask)
    );

    // A free is legal only when its whole run is in use and in range.
    always_comb begin
        free_ok = !addr_bad_q
               && (need_q != '0)
               && ((32'(start_q) + 32'(need_q)) <= 32'(eff_limit))
               && ((used_map & win_mask) == win_mask);
    end

    assign set_en = in_exec && (op_q == OP_ALLOC) && fit_found;
    assign clr_en = in_exec && (op_q == OP_FREE) && free_ok;

    fau_unit_map #(
        .MAP_BITS(MAP_BITS)
    ) u_map (
        .clk   (clk),
        .rst_n (rst_n),
        .set_en(set_en),
        .clr_en(clr_en),
        .mask  (win_mask),
        .used  (used_map)
    );

    // Result registers: one done pulse per request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_done <= 1'b0;
            rsp_err  <= 1'b0;
            rsp_addr <= '0;
        end else begin
            rsp_done <= in_exec;
            if (in_exec) begin
                if (op_q == OP_ALLOC) begin
                    rsp_err  <= !fit_found;
                    rsp_addr <= fit_found ? cfg_base + (ADDR_W'(fit_start) << UNIT_SH) : '0;
                end else begin
                    rsp_err  <= !free_ok;
                    rsp_addr <= free_ok ? addr_q : '0;
                end
            end
        end
    end
endmodule

// File: rtl/fau_alloc_checker.sv
// Protocol and state checker for fifo_unit_alloc, attached by bind.
// Purpose: checks handshake timing, the done pulse, bitmap change rules
// and address alignment.
module fau_alloc_checker #(
    parameter int ADDR_W   = 32,
    parameter int MAP_BITS = 128,
    parameter int UNIT_SH  = 9
) (
    input logic                clk,
    input logic                rst_n,
    input logic                req_valid,
    input logic                req_ready,
    input logic                rsp_done,
    input logic                rsp_err,
    input logic [ADDR_W-1:0]   rsp_addr,
    input logic [ADDR_W-1:0]   cfg_base,
    input logic [MAP_BITS-1:0] used_map
);
    logic acc;
    logic [ADDR_W-1:0] rel_addr;
    assign acc      = req_valid && req_ready && rst_n;
    assign rel_addr = rsp_addr - cfg_base;

    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (req_ready && !rsp_done)); // R1
    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> !req_ready); // R8
    AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(acc, 3) && $past(rst_n, 1) && $past(rst_n, 2)) |-> rsp_done); // R8
    AST_DONE_HAS_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> $past(acc, 3)); // R8
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done); // R8
    AST_MAP_ONLY_ON_SUCCESS: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(used_map) |-> (rsp_done && !rsp_err)); // R4
    AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_done && !rsp_err) |-> (rel_addr[UNIT_SH-1:0] == '0)); // R3
endmodule

bind fifo_unit_alloc fau_alloc_checker #(
    .ADDR_W  (ADDR_W),
    .MAP_BITS(MAP_BITS),
    .UNIT_SH (UNIT_SH)
) u_fau_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_ready(req_ready),
    .rsp_done (rsp_done),
    .rsp_err  (rsp_err),
    .rsp_addr (rsp_addr),
    .cfg_base (cfg_base),
    .used_map (used_map)
);

// File: tb/fifo_unit_alloc_tb_top.sv
// Scoreboard bench: the driver keeps a unit bitmap model, predicts each
// response and queues it; the monitor compares results as they come out.
module fifo_unit_alloc_tb_top;
    localparam logic [31:0] BASE = 32'h0000_4000;
    localparam int UNIT = 512;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cfg_base = BASE;
    logic [7:0]  cfg_limit = 8'd128;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_op = 1'b0;
    logic [10:0] req_mps = '0;
    logic [2:0]  req_slot = '0;
    logic [31:0] req_addr = '0;
    logic [16:0] req_len = '0;
    logic        rsp_done;
    logic        rsp_err;
    logic [31:0] rsp_addr;

    always #2.5 clk = ~clk;

    fifo_unit_alloc dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_base (cfg_base),
        .cfg_limit(cfg_limit),
        .req_valid(req_valid),
        .req_ready(req_ready),
        .req_op   (req_op),
        .req_mps  (req_mps),
        .req_slot (req_slot),
        .req_addr (req_addr),
        .req_len  (req_len),
        .rsp_done (rsp_done),
        .rsp_err  (rsp_err),
        .rsp_addr (rsp_addr)
    );

    typedef struct {
        bit          err;
        logic [31:0] addr;
        int          cyc;
        string       rq;
    } exp_t;

    exp_t        sb_q[$];
    bit [127:0]  mdl = '0;
    int          lim = 128;
    int          cyc = 0;
    int          n_vec = 0;
    int          n_bad = 0;
    bit          finished = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    // Unit count of an allocation, from R2.
    function automatic int alloc_units(int mps, int slot);
        int seg = 1;
        while (seg < mps) seg = seg * 2;
        return ((slot + 1) * seg + UNIT - 1) / UNIT;
    endfunction

    // Predict, then drive one request through the handshake.
    task automatic send(bit op, int mps, int slot, longint addr, int len, string rq);
        exp_t e;
        int n;
        int st;
        bit ok;
        e.rq = rq;
        if (!op) begin
            n  = alloc_units(mps, slot);
            st = -1;
            for (int s = 0; (s + n <= lim) && (st < 0); s++) begin
                ok = 1'b1;
                for (int b = s; b < s + n; b++) if (mdl[b]) ok = 1'b0;
                if (ok) st = s;
            end
            if (st >= 0) begin
                for (int b = st; b < st + n; b++) mdl[b] = 1'b1;
                e.err  = 1'b0;
                e.addr = BASE + 32'(st * UNIT);
            end else begin
                e.err  = 1'b1;
                e.addr = '0;
            end
        end else begin
            n  = (len + UNIT - 1) / UNIT;
            ok = (addr >= longint'(BASE)) && (((addr - longint'(BASE)) % UNIT) == 0) && (len > 0);
            st = 0;
            if (ok) begin
                st = int'((addr - longint'(BASE)) / UNIT);
                if (st + n > lim) ok = 1'b0;
            end
            if (ok) for (int b = st; b < st + n; b++) if (!mdl[b]) ok = 1'b0;
            if (ok) begin
                for (int b = st; b < st + n; b++) mdl[b] = 1'b0;
                e.err  = 1'b0;
                e.addr = addr[31:0];
            end else begin
                e.err  = 1'b1;
                e.addr = '0;
            end
        end
        @(negedge clk);
        req_op    = op;
        req_mps   = 11'(mps);
        req_slot  = 3'(slot);
        req_addr  = addr[31:0];
        req_len   = 17'(len);
        req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        e.cyc = cyc + 3;
        sb_q.push_back(e);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic drain();
        while (sb_q.size() > 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic set_limit(int l);
        drain();
        lim       = (l > 128) ? 128 : l;
        cfg_limit = 8'(l);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    // Monitor: compare each response with the head of the scoreboard.
    always @(negedge clk) begin
        if (rst_n && rsp_done) begin
            n_vec++;
            if (sb_q.size() == 0) begin
                n_bad++;
                $display("FAIL R8 unexpected done: actual err=%0b addr=%h, expected no response",
                         rsp_err, rsp_addr);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                if (rsp_err !== e.err || rsp_addr !== e.addr) begin
                    n_bad++;
                    $display("FAIL %s: actual err=%0b addr=%h, expected err=%0b addr=%h",
                             e.rq, rsp_err, rsp_addr, e.err, e.addr);
                end
                if (cyc != e.cyc) begin
                    n_bad++;
                    $display("FAIL R8 latency: actual cycle %0d, expected cycle %0d", cyc, e.cyc);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_vec++;
            n_bad++;
            $display("FAIL R8 watchdog: actual no completion, expected completion");
            summary();
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle after reset
        n_vec++;
        if (req_ready !== 1'b1 || rsp_done !== 1'b0) begin
            n_bad++;
            $display("FAIL R1 reset: actual ready=%0b done=%0b, expected ready=1 done=0",
                     req_ready, rsp_done);
        end
        send(0, 512, 2, 0, 0, "R2 mps512 slot2 -> 3 units at 0");
        send(0, 100, 1, 0, 0, "R2 mps100 slot1 -> 1 unit at 3");
        send(0, 1024, 2, 0, 0, "R5 mps1024 slot2 -> 6 units after live ones");
        send(0, 513, 0, 0, 0, "R2 mps513 rounds to 1024 -> 2 units");
        send(1, 0, 0, longint'(BASE) + 3 * UNIT, 256, "R6 free one unit at 3");
        send(0, 64, 3, 0, 0, "R3 first fit reuses unit 3");
        send(1, 0, 0, longint'(BASE), 1536, "R6 free units 0..2");
        send(0, 1024, 1, 0, 0, "R3 4 units skip 3-unit hole");
        send(1, 0, 0, longint'(BASE), 512, "R7 free of already clear unit");
        send(1, 0, 0, longint'(BASE) + 100, 512, "R7 misaligned free");
        send(1, 0, 0, longint'(BASE) - UNIT, 512, "R7 free below base");
        send(1, 0, 0, longint'(BASE) + 10 * UNIT, 0, "R7 zero length free");
        set_limit(20);
        send(0, 1024, 7, 0, 0, "R4 16 units do not fit below limit 20");
        send(0, 1024, 1, 0, 0, "R4 4 units end exactly at limit");
        send(0, 512, 0, 0, 0, "R3 single unit at 0");
        send(0, 512, 2, 0, 0, "R4 3 units no room");
        send(1, 0, 0, longint'(BASE) + 16 * UNIT, 2048, "R6 free units 16..19");
        send(1, 0, 0, longint'(BASE) + 18 * UNIT, 2048, "R7 free past limit");
        set_limit(128);
        send(0, 1024, 7, 0, 0, "R5 16 units at 16");
        for (int k = 0; k < 7; k++) send(0, 1024, 7, 0, 0, "R5 fill memory");
        send(0, 1024, 7, 0, 0, "R4 memory full");
        send(0, 64, 0, 0, 0, "R3 single unit fills hole at 1");
        drain();
        finished = 1'b1;
        summary();
    end
endmodule